// File: doc/BRIEF.md
# Time-Duplexed Packet Memory Arbiter

This block lets two requesters share one single-port packet buffer of 256 words by 16 bits (512 bytes) as if it were a dual-port RAM. One requester is the host register bus, the other is the USB transaction engine. Each side presents an address, write data and a write flag together with a request. The arbiter picks at most one owner per clock. That owner's access goes to the RAM on that clock edge.

Memory cycles alternate between an even and an odd slot. On an even slot the USB side wins a contested cycle; on an odd slot the host wins. An uncontested slot goes to whichever side asks for it. This gives the USB side at least half of the cycles under continuous host traffic, so its transfers still complete. The host can run bursts of any length that only stall on the reserved slots. Read data comes back one cycle after the grant, with a valid strobe on the port that was granted.

Top module: `pma_arbiter`

## Requirements
- R1: The memory holds 256 independent 16-bit words. A word written through either port is returned unchanged by a later read of the same address through either port.
- R2: On an even slot with both sides requesting, only the USB side is granted (`usb_gnt`=1, `host_ready`=0). The first cycle after reset is even, and the parity flips on every clock whether or not anyone requests.
- R3: On an odd slot with both sides requesting, only the host is granted (`host_ready`=1, `usb_gnt`=0).
- R4: When only one side requests, that side is granted in either slot parity. When neither requests, nothing is granted.
- R5: At most one grant is active per cycle, and a grant is never given to a side that is not requesting.
- R6: A granted read (write flag 0) raises that port's read-valid strobe in the next cycle, with the addressed word on its read-data output. A granted write or a missing grant leaves the strobe low in the next cycle.
- R7: A side that keeps requesting is never refused on two consecutive cycles.
- R8: While reset is high, no grant is given, no RAM write occurs and both read-valid strobes are low.
- R9: A host burst that runs alongside continuous USB traffic is granted on alternate cycles. Each stalled word is written with the address and data it held while waiting, and no word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until ready |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_we | input | 1 | Host write (1) or read (0) |
| host_ready | output | 1 | Host access accepted this cycle |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 16 | Host read data |
| usb_req | input | 1 | USB-side access request |
| usb_addr | input | 8 | USB-side word address |
| usb_wdata | input | 16 | USB-side write data |
| usb_we | input | 1 | USB-side write (1) or read (0) |
| usb_gnt | output | 1 | USB-side access accepted this cycle |
| usb_rvalid | output | 1 | USB-side read data valid |
| usb_rdata | output | 16 | USB-side read data |

## Verification
The case that is hardest to reach is a long host burst that stalls again and again against a USB side that never stops requesting. In that case each stalled word has to land intact and neither side may lose two slots in a row. The bench drives a 64-word host write burst while the USB side reads a separate region without pause. The burst advances only on `host_ready`, and the bench counts consecutive refusals per side. The burst region is then read back through both ports. A long mixed phase uses pseudo-random requests, addresses and directions and checks every grant against the slot parity the bench tracks for itself.

// File: rtl/pma_pkg.sv
package pma_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_USB  = 2'd2
    } owner_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_req_t;

    // Slot owner from slot parity and the two requests.
    function automatic owner_e pick_owner(input logic odd_slot,
                                          input logic h_req,
                                          input logic u_req);
        owner_e o;
        if (h_req && u_req) o = odd_slot ? OWN_HOST : OWN_USB;
        else if (h_req)     o = OWN_HOST;
        else if (u_req)     o = OWN_USB;
        else                o = OWN_NONE;
        return o;
    endfunction

endpackage

// File: rtl/pma_slot_phase.sv
module pma_slot_phase (
    input  logic clk,
    input  logic rst,
    output logic odd_slot
);
    always_ff @(posedge clk) begin
        if (rst) odd_slot <= 1'b0;
        else     odd_slot <= ~odd_slot;
    end
endmodule

// File: rtl/pma_arb_core.sv
module pma_arb_core
    import pma_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          rst,
    input  logic          odd_slot,
    input  logic          h_req,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          h_we,
    input  logic          u_req,
    input  logic [AW-1:0] u_addr,
    input  logic [DW-1:0] u_wdata,
    input  logic          u_we,
    output owner_e        owner,
    output mem_req_t      mreq
);
    always_comb begin
        owner = rst ? OWN_NONE : pick_owner(odd_slot, h_req, u_req);
        mreq  = '0;
        unique case (owner)
            OWN_HOST: begin
                mreq.en    = 1'b1;
                mreq.we    = h_we;
                mreq.addr  = h_addr;
                mreq.wdata = h_wdata;
            end
            OWN_USB: begin
                mreq.en    = 1'b1;
                mreq.we    = u_we;
                mreq.addr  = u_addr;
                mreq.wdata = u_wdata;
            end
            default: mreq = '0;
        endcase
    end
endmodule

// File: rtl/pma_spram.sv
module pma_spram
    import pma_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic     clk,
    input  mem_req_t mreq,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (mreq.en) begin
            if (mreq.we) store[mreq.addr] <= mreq.wdata;
            else         rdata            <= store[mreq.addr];
        end
    end
endmodule

// File: rtl/pma_rd_tag.sv
module pma_rd_tag (
    input  logic clk,
    input  logic rst,
    input  logic h_rd_grant,
    input  logic u_rd_grant,
    output logic h_rvalid,
    output logic u_rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            h_rvalid <= 1'b0;
            u_rvalid <= 1'b0;
        end else begin
            h_rvalid <= h_rd_grant;
            u_rvalid <= u_rd_grant;
        end
    end
endmodule

// File: rtl/pma_arbiter.sv
module pma_arbiter
    import pma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              usb_req,
    input  logic [ADDR_W-1:0] usb_addr,
    input  logic [DATA_W-1:0] usb_wdata,
    input  logic              usb_we,
    output logic              usb_gnt,
    output logic              usb_rvalid,
    output logic [DATA_W-1:0] usb_rdata
);
    logic          odd_slot;
    owner_e        owner;
    mem_req_t      mreq;
    logic          ram_we;
    logic [DATA_W-1:0] ram_q;

    pma_slot_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .odd_slot (odd_slot)
    );

    pma_arb_core #(.AW(ADDR_W), .DW(DATA_W)) u_core (
        .rst      (rst),
        .odd_slot (odd_slot),
        .h_req    (host_req),
        .h_addr   (host_addr),
        .h_wdata  (host_wdata),
        .h_we     (host_we),
        .u_req    (usb_req),
        .u_addr   (usb_addr),
        .u_wdata  (usb_wdata),
        .u_we     (usb_we),
        .owner    (owner),
        .mreq     (mreq)
    );

    pma_spram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .mreq  (mreq),
        .rdata (ram_q)
    );

    assign host_ready = (owner == OWN_HOST);
    assign usb_gnt    = (owner == OWN_USB);
    assign ram_we     = mreq.en && mreq.we;

    pma_rd_tag u_tag (
        .clk        (clk),
        .rst        (rst),
        .h_rd_grant (host_ready && !host_we),
        .u_rd_grant (usb_gnt && !usb_we),
        .h_rvalid   (host_rvalid),
        .u_rvalid   (usb_rvalid)
    );

    assign host_rdata = ram_q;
    assign usb_rdata  = ram_q;
endmodule

// File: rtl/pma_arbiter_chk.sv
module pma_arbiter_chk (
    input logic clk,
    input logic rst,
    input logic host_req,
    input logic host_we,
    input logic host_ready,
    input logic host_rvalid,
    input logic usb_req,
    input logic usb_we,
    input logic usb_gnt,
    input logic usb_rvalid,
    input logic ram_we
);
    // R5
    a_r5_one_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0({host_ready, usb_gnt}));
    // R5
    a_r5_host_asked: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> host_req);
    // R5
    a_r5_usb_asked: assert property (@(posedge clk) disable iff (rst)
        usb_gnt |-> usb_req);
    // R7
    a_r7_host_wait: assert property (@(posedge clk) disable iff (rst)
        (host_req && !host_ready) ##1 host_req |-> host_ready);
    // R7
    a_r7_usb_wait: assert property (@(posedge clk) disable iff (rst)
        (usb_req && !usb_gnt) ##1 usb_req |-> usb_gnt);
    // R2 / R3: contested slots alternate owner
    a_r3_alternate: assert property (@(posedge clk) disable iff (rst)
        (host_req && usb_req && usb_gnt) ##1 (host_req && usb_req) |-> host_ready);
    // R6
    a_r6_host_rvalid: assert property (@(posedge clk) disable iff (rst)
        (host_ready && !host_we) |=> host_rvalid);
    // R6
    a_r6_host_rvalid_cause: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(host_ready && !host_we));
    // R6
    a_r6_usb_rvalid: assert property (@(posedge clk) disable iff (rst)
        (usb_gnt && !usb_we) |=> usb_rvalid);
    // R8
    a_r8_quiet_reset: assert property (@(posedge clk)
        rst |-> (!host_ready && !usb_gnt && !ram_we));
endmodule

bind pma_arbiter pma_arbiter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .usb_req     (usb_req),
    .usb_we      (usb_we),
    .usb_gnt     (usb_gnt),
    .usb_rvalid  (usb_rvalid),
    .ram_we      (ram_we)
);

// File: tb/tb_pma_arbiter.sv
module tb_pma_arbiter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0, usb_req = 1'b0, usb_we = 1'b0;
    logic [7:0]  host_addr = '0, usb_addr = '0;
    logic [15:0] host_wdata = '0, usb_wdata = '0;
    logic        host_ready, host_rvalid, usb_gnt, usb_rvalid;
    logic [15:0] host_rdata, usb_rdata;

    int errors = 0;
    int checks = 0;
    logic ph = 1'b0;
    logic [15:0] shadow [256];
    int hmiss = 0, umiss = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pma_arbiter dut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
        .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .usb_req(usb_req), .usb_addr(usb_addr), .usb_wdata(usb_wdata), .usb_we(usb_we),
        .usb_gnt(usb_gnt), .usb_rvalid(usb_rvalid), .usb_rdata(usb_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check grants, then read-back after the rising edge.
    task automatic step(input logic hr, input logic [7:0] ha, input logic [15:0] hd, input logic hw,
                        input logic ur, input logic [7:0] ua, input logic [15:0] ud, input logic uw,
                        output logic hg, output logic ug);
        logic eh, eu, ehv, euv;
        logic [15:0] erh, eru;
        string tag;
        host_req = hr; host_addr = ha; host_wdata = hd; host_we = hw;
        usb_req = ur;  usb_addr = ua;  usb_wdata = ud;  usb_we = uw;
        #1;
        eh = hr && (!ur || ph);
        eu = ur && (!hr || !ph);
        if (hr && ur) tag = ph ? "R3" : "R2";
        else          tag = "R4";
        chk(host_ready == eh, tag, "host_ready", int'(host_ready), int'(eh));
        chk(usb_gnt == eu, tag, "usb_gnt", int'(usb_gnt), int'(eu));
        chk(!(host_ready && usb_gnt), "R5", "two grants", 1, 0);
        hg = host_ready; ug = usb_gnt;
        if (hr && !hg) hmiss++; else hmiss = 0;
        if (ur && !ug) umiss++; else umiss = 0;
        if (hmiss > 1) chk(1'b0, "R7", "host refused twice", hmiss, 1);
        if (umiss > 1) chk(1'b0, "R7", "usb refused twice", umiss, 1);
        ehv = hg && !hw; erh = shadow[ha];
        euv = ug && !uw; eru = shadow[ua];
        if (hg && hw) shadow[ha] = hd;
        if (ug && uw) shadow[ua] = ud;
        @(posedge clk);
        ph = ~ph;
        @(negedge clk);
        chk(host_rvalid == ehv, "R6", "host_rvalid", int'(host_rvalid), int'(ehv));
        chk(usb_rvalid == euv, "R6", "usb_rvalid", int'(usb_rvalid), int'(euv));
        if (ehv) chk(host_rdata == erh, "R1", "host_rdata", int'(host_rdata), int'(erh));
        if (euv) chk(usb_rdata == eru, "R1", "usb_rdata", int'(usb_rdata), int'(eru));
    endtask

    function automatic logic [15:0] pat(input int a, input int seed);
        return 16'((a * 40503 + seed * 977) ^ (a << 7));
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic hg, ug;
        logic [15:0] lfsr;
        int wr_idx, rd_idx;
        for (int i = 0; i < 256; i++) shadow[i] = 16'hxxxx;

        // R8: requests and writes are held during reset; nothing must be granted.
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; usb_req = 1'b1; usb_we = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(!host_ready && !usb_gnt, "R8", "grant in reset", int'({host_ready, usb_gnt}), 0);
            @(negedge clk);
            chk(!host_rvalid && !usb_rvalid, "R8", "rvalid in reset", int'({host_rvalid, usb_rvalid}), 0);
        end
        rst = 1'b0; ph = 1'b0;

        // Sweep of request pairs over both slot parities (R2, R3, R4).
        for (int i = 0; i < 16; i++)
            step(i[1], 8'(i), 16'(i), 1'b1, i[2], 8'(i + 100), 16'(i), 1'b1, hg, ug);

        // R1, R4: host fills every word alone, the USB side reads every word alone.
        for (int a = 0; a < 256; a++)
            step(1'b1, 8'(a), pat(a, 1), 1'b1, 1'b0, 8'd0, 16'd0, 1'b0, hg, ug);
        for (int a = 0; a < 256; a++)
            step(1'b0, 8'd0, 16'd0, 1'b0, 1'b1, 8'(a), 16'd0, 1'b0, hg, ug);

        // R9: host write burst against continuous USB reads of another region.
        wr_idx = 0; rd_idx = 0;
        while (wr_idx < 64) begin
            step(1'b1, 8'(wr_idx), pat(wr_idx, 2), 1'b1,
                 1'b1, 8'(64 + rd_idx % 64), 16'd0, 1'b0, hg, ug);
            if (hg) wr_idx++;
            if (ug) rd_idx++;
        end
        chk(rd_idx >= 63 && rd_idx <= 65, "R9", "usb share during burst", rd_idx, 64);
        // R9: read the burst region back through both ports.
        for (int a = 0; a < 64; a++) begin
            step(1'b1, 8'(a), 16'd0, 1'b0, 1'b0, 8'd0, 16'd0, 1'b0, hg, ug);
            chk(shadow[a] == pat(a, 2), "R9", "burst word", int'(shadow[a]), int'(pat(a, 2)));
        end
        for (int a = 0; a < 64; a++)
            step(1'b0, 8'd0, 16'd0, 1'b0, 1'b1, 8'(a), 16'd0, 1'b0, hg, ug);

        // Mixed pseudo-random traffic (R1..R7).
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[8:1], pat(i, 3), lfsr[9],
                 lfsr[10], {lfsr[15:11], lfsr[2:0]}, pat(i, 4), lfsr[11], hg, ug);
        end

        step(1'b0, 8'd0, 16'd0, 1'b0, 1'b0, 8'd0, 16'd0, 1'b0, hg, ug);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule